// File: doc/BRIEF.md
# Four-Channel Sequenced Pulse-Width Generator

This block drives four pulse-width outputs from one shared period counter. The counter advances once per prescaled tick: either upward and wrapping, for edge-aligned pulses, or up then back down, for center-aligned pulses. Each channel compares the live count against its own compare value. Bit 15 of that value chooses the channel's polarity, and bits 14:0 hold the threshold.

A sequencer outside the block presents 16-bit samples with a valid strobe, one sample per cycle at most. A two-bit load selector decides how the samples are spread:

- one sample for all channels,
- a sample per channel pair,
- a sample per channel,
- three channel samples followed by a fresh counter top.

Decoded samples wait in a staging set. They move into the active set only when a period ends, and the block pulses a period-end strobe so the sequencer can pace its samples.

Configuration arrives on plain input pins: enable, prescaler, count direction mode, top value and load selector. While the enable is low, the counter and the outputs rest at zero, and incoming samples are dropped.

Top module: `seqpwm_core`

## Requirements
- R1: After reset, and on every cycle after a cycle with `cfg_enable` low, `pwm_out` is 0, `period_end` is 0 and the counter is 0.
- R2: The counter advances once every 2^`cfg_prescale` clock cycles (0 gives 1, 7 gives 128). It holds its value between ticks.
- R3: With `cfg_updown`=0, the counter runs 0..top and wraps, so one period lasts top+1 ticks. A channel whose sample bit 15 is 0 is high while count >= compare (bits 14:0), so it is high for top-compare+1 ticks when compare <= top.
- R4: A channel whose sample bit 15 is 1 is high while count < compare, and low otherwise.
- R5: With `cfg_updown`=1, the counter climbs to top and falls back to 0, so one period lasts 2*top ticks. With bit 15 = 0 and 1 <= compare <= top, a channel is high for 2*(top-compare)+1 ticks.
- R6: Load selector 0 (shared): each sample writes all four channels.
- R7: Load selector 1 (pairs): samples alternate. The first writes channels 0 and 1, the next writes channels 2 and 3.
- R8: Load selector 2 (per channel): samples cycle through channels 0, 1, 2, 3 in that order.
- R9: Load selector 3 (waveform): in each group of four samples, the first three write channels 0..2. The fourth sample's bits 14:0 become the counter top, and `cfg_top` is ignored.
- R10: Compare values and the top value take effect only at a period boundary. A `cfg_top` change in mid-period does not shorten the running period.
- R11: Samples presented while `cfg_enable` is low are ignored. Group position restarts at the first slot when the block is enabled.
- R12: `period_end` is a one-cycle strobe, one per period, raised the cycle after the counter restarts its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run enable; low holds counter and outputs at zero |
| cfg_prescale | input | 3 | Clock divide exponent, divide by 2^value |
| cfg_updown | input | 1 | 0 = wrap-around counting, 1 = up-then-down counting |
| cfg_top | input | 15 | Counter top value outside waveform load mode |
| cfg_load | input | 2 | Sample spread: 0 shared, 1 pairs, 2 per channel, 3 waveform |
| smp_data | input | 16 | Sample: bit 15 polarity, bits 14:0 compare or top |
| smp_valid | input | 1 | Sample present this cycle |
| pwm_out | output | 4 | Pulse outputs, one per channel |
| period_end | output | 1 | One-cycle strobe after each period boundary |

## Verification
The bound checker enforces several properties on every cycle:

- idle-low behaviour after a disabled cycle,
- the counter holding between prescaler ticks,
- the count never exceeding the active top,
- the period strobe landing on a restarted count,
- active compare and top values changing only at a boundary or while disabled.

The bench's directed scenarios cover what only whole periods can show. They measure the actual duty and period length for each load mode, for both polarities, for both count directions and for a non-unit prescaler. They also check that a mid-period top change leaves the running period intact, and that samples offered while disabled change nothing.

// File: rtl/seqpwm_pkg.sv
package seqpwm_pkg;
  typedef enum logic [1:0] {
    LD_SHARED = 2'd0,
    LD_PAIRS  = 2'd1,
    LD_EACH   = 2'd2,
    LD_WAVE   = 2'd3
  } load_mode_e;
endpackage

// File: rtl/seqpwm_prediv.sv
module seqpwm_prediv #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int unsigned PRE_W = (1 << PSC_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int b = 0; b < PRE_W; b++) mask[b] = (b < int'(psc));
    pre_d = en ? pre_q + 1'b1 : '0;
    tick  = en && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/seqpwm_count.sv
module seqpwm_count #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned TOP_RST = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             updown,
  input  logic [CNT_W-1:0] top_next,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top_act,
  output logic             bnd
);
  logic [CNT_W-1:0] cnt_q, cnt_d, top_q;
  logic             dn_q, dn_d;
  logic             cnt_en, top_en;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    bnd   = 1'b0;
    if (!en) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      if (!updown) begin
        dn_d = 1'b0;
        if (cnt_q >= top_q) begin
          cnt_d = '0;
          bnd   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (!dn_q) begin
        if (top_q == '0) begin
          cnt_d = '0;
          bnd   = 1'b1;
        end else if (cnt_q >= top_q) begin
          cnt_d = top_q - 1'b1;
          dn_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          bnd   = 1'b1;
          dn_d  = 1'b0;
          cnt_d = (top_next == '0) ? '0 : CNT_W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_en = !en || tick;
  assign top_en = !en || bnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= CNT_W'(TOP_RST);
    else if (top_en) top_q <= top_next;
  end

  assign cnt     = cnt_q;
  assign top_act = top_q;
endmodule

// File: rtl/seqpwm_unpack.sv
module seqpwm_unpack
  import seqpwm_pkg::*;
#(
  parameter int unsigned CH_NUM  = 4,
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned TOP_RST = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  load_mode_e                   mode,
  input  logic [CNT_W:0]               smp_data,
  input  logic                         smp_valid,
  output logic [CH_NUM-1:0][CNT_W:0]   pend,
  output logic [CNT_W-1:0]             wave_top
);
  localparam int unsigned IDX_W = $clog2(CH_NUM);
  localparam logic [CNT_W:0] IDLE_SMP = {1'b1, {CNT_W{1'b0}}};

  logic [CH_NUM-1:0][CNT_W:0] pend_q, pend_d;
  logic [CNT_W-1:0]           wtop_q, wtop_d;
  logic [IDX_W-1:0]           idx_q, idx_d, pair_lo, pair_hi;
  logic                       take, idx_en;

  assign take    = en && smp_valid;
  assign idx_en  = !en || smp_valid;
  assign pair_lo = IDX_W'({idx_q[0], 1'b0});
  assign pair_hi = IDX_W'({idx_q[0], 1'b1});

  always_comb begin
    pend_d = pend_q;
    wtop_d = wtop_q;
    idx_d  = idx_q;
    if (!en) begin
      idx_d = '0;
    end else if (smp_valid) begin
      unique case (mode)
        LD_SHARED: begin
          for (int c = 0; c < CH_NUM; c++) pend_d[c] = smp_data;
          idx_d = '0;
        end
        LD_PAIRS: begin
          pend_d[pair_lo] = smp_data;
          pend_d[pair_hi] = smp_data;
          idx_d = IDX_W'(!idx_q[0]);
        end
        LD_EACH: begin
          pend_d[idx_q] = smp_data;
          idx_d = idx_q + 1'b1;
        end
        LD_WAVE: begin
          if (idx_q == IDX_W'(CH_NUM - 1)) wtop_d = smp_data[CNT_W-1:0];
          else                             pend_d[idx_q] = smp_data;
          idx_d = idx_q + 1'b1;
        end
        default: idx_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= {CH_NUM{IDLE_SMP}};
      wtop_q <= CNT_W'(TOP_RST);
    end else if (take) begin
      pend_q <= pend_d;
      wtop_q <= wtop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign pend     = pend_q;
  assign wave_top = wtop_q;
endmodule

// File: rtl/seqpwm_lane.sv
module seqpwm_lane #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             reload,
  input  logic [CNT_W:0]   pend_smp,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0]   cmp_act,
  output logic             pwm
);
  logic [CNT_W:0] cmp_q;
  logic           out_q, out_d, above;

  assign above = cnt >= cmp_q[CNT_W-1:0];
  assign out_d = en && (cmp_q[CNT_W] ? !above : above);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= {1'b1, {CNT_W{1'b0}}};
    else if (reload) cmp_q <= pend_smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign cmp_act = cmp_q;
  assign pwm     = out_q;
endmodule

// File: rtl/seqpwm_core.sv
module seqpwm_core
  import seqpwm_pkg::*;
#(
  parameter int unsigned CH_NUM  = 4,
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned PSC_W   = 3,
  parameter int unsigned TOP_RST = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [PSC_W-1:0]  cfg_prescale,
  input  logic              cfg_updown,
  input  logic [CNT_W-1:0]  cfg_top,
  input  logic [1:0]        cfg_load,
  input  logic [CNT_W:0]    smp_data,
  input  logic              smp_valid,
  output logic [CH_NUM-1:0] pwm_out,
  output logic              period_end
);
  logic [1:0]                 rsync_q;
  logic                       rst_n_i;
  logic                       tick, bnd, reload, pe_q;
  logic [CNT_W-1:0]           cnt_q, top_act, top_next, wave_top;
  logic [CH_NUM-1:0][CNT_W:0] pend, cmp_flat;
  load_mode_e                 mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  assign mode     = load_mode_e'(cfg_load);
  assign top_next = (mode == LD_WAVE) ? wave_top : cfg_top;
  assign reload   = !cfg_enable || bnd;

  seqpwm_prediv #(.PSC_W(PSC_W)) i_prediv (
    .clk(clk), .rst_n(rst_n_i), .en(cfg_enable), .psc(cfg_prescale), .tick(tick)
  );

  seqpwm_count #(.CNT_W(CNT_W), .TOP_RST(TOP_RST)) i_count (
    .clk(clk), .rst_n(rst_n_i), .en(cfg_enable), .tick(tick), .updown(cfg_updown),
    .top_next(top_next), .cnt(cnt_q), .top_act(top_act), .bnd(bnd)
  );

  seqpwm_unpack #(.CH_NUM(CH_NUM), .CNT_W(CNT_W), .TOP_RST(TOP_RST)) i_unpack (
    .clk(clk), .rst_n(rst_n_i), .en(cfg_enable), .mode(mode), .smp_data(smp_data),
    .smp_valid(smp_valid), .pend(pend), .wave_top(wave_top)
  );

  for (genvar g = 0; g < CH_NUM; g++) begin : g_lane
    seqpwm_lane #(.CNT_W(CNT_W)) i_lane (
      .clk(clk), .rst_n(rst_n_i), .en(cfg_enable), .reload(reload),
      .pend_smp(pend[g]), .cnt(cnt_q), .cmp_act(cmp_flat[g]), .pwm(pwm_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pe_q <= 1'b0;
    else          pe_q <= bnd;
  end
  assign period_end = pe_q;
endmodule

// File: rtl/seqpwm_core_chk.sv
module seqpwm_core_chk #(
  parameter int unsigned CH_NUM = 4,
  parameter int unsigned CNT_W  = 15
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic [CH_NUM-1:0]          pwm_out,
  input logic                       period_end,
  input logic                       tick,
  input logic                       bnd,
  input logic [CNT_W-1:0]           cnt,
  input logic [CNT_W-1:0]           top_act,
  input logic [CH_NUM-1:0][CNT_W:0] cmp_flat
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_out == '0 && !period_end && cnt == '0));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_act);

  p_staged_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bnd) |=> ($stable(cmp_flat) && $stable(top_act)));

  p_strobe_at_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> cnt <= CNT_W'(1));
endmodule

bind seqpwm_core seqpwm_core_chk #(.CH_NUM(CH_NUM), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg_enable), .pwm_out(pwm_out),
  .period_end(period_end), .tick(tick), .bnd(bnd), .cnt(cnt_q),
  .top_act(top_act), .cmp_flat(cmp_flat)
);

// File: tb/test_seqpwm_core.sv
`timescale 1ns/1ps
module test_seqpwm_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [2:0]  cfg_prescale;
  logic        cfg_updown;
  logic [14:0] cfg_top;
  logic [1:0]  cfg_load;
  logic [15:0] smp_data;
  logic        smp_valid;
  logic [3:0]  pwm_out;
  logic        period_end;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int meas_len;
  int meas_hi [4];

  always #2.5 clk = ~clk;

  seqpwm_core i_seqpwm_core (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_prescale(cfg_prescale),
    .cfg_updown(cfg_updown), .cfg_top(cfg_top), .cfg_load(cfg_load),
    .smp_data(smp_data), .smp_valid(smp_valid), .pwm_out(pwm_out), .period_end(period_end)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d exp below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk);
    smp_data  = d;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_pe();
    do @(negedge clk); while (!period_end);
  endtask

  task automatic measure();
    wait_pe();
    meas_len = 0;
    for (int c = 0; c < 4; c++) meas_hi[c] = 0;
    do begin
      @(negedge clk);
      meas_len++;
      for (int c = 0; c < 4; c++) meas_hi[c] += int'(pwm_out[c]);
    end while (!period_end);
  endtask

  task automatic settle_measure();
    wait_pe();
    wait_pe();
    measure();
  endtask

  task automatic t_reset();
    chk("R1 reset pwm_out", int'(pwm_out), 0);
    chk("R1 reset period_end", int'(period_end), 0);
  endtask

  task automatic t_shared();
    cfg_load = 2'd0; cfg_top = 15'd99; cfg_enable = 1'b1;
    send(16'd40);
    settle_measure();
    chk("R3 up period", meas_len, 100);
    for (int c = 0; c < 4; c++) chk("R6 shared duty", meas_hi[c], 60);
  endtask

  task automatic t_polarity();
    send(16'h8000 | 16'd30);
    settle_measure();
    for (int c = 0; c < 4; c++) chk("R4 inverted duty", meas_hi[c], 30);
  endtask

  task automatic t_each();
    cfg_load = 2'd2;
    send(16'd10); send(16'd20); send(16'd30); send(16'd40);
    settle_measure();
    chk("R8 ch0", meas_hi[0], 90);
    chk("R8 ch1", meas_hi[1], 80);
    chk("R8 ch2", meas_hi[2], 70);
    chk("R8 ch3", meas_hi[3], 60);
  endtask

  task automatic t_pairs();
    cfg_load = 2'd1;
    send(16'd25); send(16'h8000 | 16'd50);
    settle_measure();
    chk("R7 ch0", meas_hi[0], 75);
    chk("R7 ch1", meas_hi[1], 75);
    chk("R7 ch2", meas_hi[2], 50);
    chk("R7 ch3", meas_hi[3], 50);
  endtask

  task automatic t_wave();
    cfg_load = 2'd3;
    send(16'd10); send(16'd20); send(16'd30); send(16'd49);
    settle_measure();
    chk("R9 wave period", meas_len, 50);
    chk("R9 ch0", meas_hi[0], 40);
    chk("R9 ch1", meas_hi[1], 30);
    chk("R9 ch2", meas_hi[2], 20);
    chk("R9 ch3 untouched", meas_hi[3], 50);
    cfg_load = 2'd0;
  endtask

  task automatic t_updown();
    cfg_load = 2'd0; cfg_top = 15'd20; cfg_updown = 1'b1;
    send(16'd5);
    settle_measure();
    chk("R5 updown period", meas_len, 40);
    chk("R5 updown duty", meas_hi[0], 31);
    cfg_updown = 1'b0;
  endtask

  task automatic t_prescale();
    cfg_top = 15'd9; cfg_prescale = 3'd2;
    send(16'd5);
    settle_measure();
    chk("R2 div4 period", meas_len, 40);
    chk("R2 div4 duty", meas_hi[1], 20);
    cfg_prescale = 3'd0;
  endtask

  task automatic t_boundary();
    int n;
    cfg_top = 15'd99;
    settle_measure();
    chk("R12 one strobe per period", meas_len, 100);
    wait_pe();
    wait_cyc(5);
    cfg_top = 15'd49;
    n = 0;
    do begin @(negedge clk); n++; end while (!period_end);
    chk("R10 running period kept", n, 95);
    measure();
    chk("R10 new top next period", meas_len, 50);
  endtask

  task automatic t_disabled();
    int hi;
    cfg_top = 15'd99; cfg_load = 2'd0;
    send(16'd40);
    settle_measure();
    chk("R11 before disable", meas_hi[0], 60);
    cfg_enable = 1'b0;
    wait_cyc(2);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hi += int'(pwm_out != 4'd0) + int'(period_end);
    end
    chk("R1 disabled outputs low", hi, 0);
    send(16'd0);
    cfg_enable = 1'b1;
    settle_measure();
    chk("R11 sample ignored when disabled", meas_hi[0], 60);
    cfg_load = 2'd2;
    send(16'd77);
    cfg_enable = 1'b0;
    wait_cyc(3);
    cfg_enable = 1'b1;
    send(16'd10); send(16'd20); send(16'd30); send(16'd40);
    settle_measure();
    chk("R11 restart ch0", meas_hi[0], 90);
    chk("R11 restart ch3", meas_hi[3], 60);
  endtask

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_prescale = 3'd0; cfg_updown = 1'b0;
    cfg_top = 15'd99; cfg_load = 2'd0; smp_data = '0; smp_valid = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_shared();
    t_polarity();
    t_each();
    t_pairs();
    t_wave();
    t_updown();
    t_prescale();
    t_boundary();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule